// File: doc/BRIEF.md
# Debug Breakpoint Status and Halt-Cause Register

This block is the control and status register of an on-chip debug unit. It follows a hardware breakpoint through an arm-and-trigger sequence of one or two levels and shows where that sequence stands as a 4-bit status nibble. The nibble goes to the trace data output whenever that port is free. The block also keeps sticky flags that record why the core entered debug mode: a catastrophic fault-on-fault, a hardware trigger, a halt instruction, or the external break pin. Each flag stays set until the debugger reads the register.

A debugger reaches the register through a request/response channel. A request is a read or a write. A write updates two control bits: one holds the processor-status clock output quiet, and the other turns the active-low break pin into an edge-triggered debug interrupt source. In that interrupt mode, a falling edge on the pin makes a request pending. The request is issued as a one-cycle pulse at the next per-instruction sample point and stays in service until the core signals completion. Interrupts do not nest.

The request channel uses valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. Only reads produce a response. `req_ready` is high whenever the single response slot is empty or is being emptied in that cycle. A response stays valid with stable data until the consumer accepts it with `rsp_ready`.

Top module: `dbg_csr`

## Requirements
- R1: The status nibble is {code[2:0], 0}. The codes are: 000 idle, 001 waiting for level 1, 010 level 1 hit, 101 waiting for level 2, 110 level 2 hit. In single-level mode, a `lvl1_hit` while waiting for level 1 moves the code to 010. The 010 code then holds, and a `lvl2_hit` while waiting for level 1 has no effect.
- R2: In two-level mode, a `lvl1_hit` while waiting for level 1 moves the code to 101. A `lvl2_hit` at 101 moves it to 110, and 110 then holds.
- R3: A pulse on `tdr_wr` sets the code to 000 when `tdr_levels` = 00. For any other value it sets the code to 001, and it selects two-level mode when `tdr_levels[1]` = 1. The write takes priority over a hit in the same cycle, and hits have no effect while the code is 000.
- R4: The four cause flags are sticky. They are read at bits 27 (fault-on-fault), 26 (hardware trigger), 25 (halt instruction) and 24 (break pin), and are also shown on `cause_flags[3:0]` in the same order. A flag is set one cycle after its event. An accepted read returns the flags and then clears them.
- R5: If a cause event and an accepted read fall in the same cycle, the read returns the old flag value and the flag is left set.
- R6: `trc_valid` equals the inverse of `trace_busy`, and `trc_status` carries the status nibble.
- R7: While control bit 1 is 0, a low `brk_pin_n` sets the break-pin flag and raises no interrupt. While the bit is 1, a high-to-low edge on the pin makes a request pending and leaves the flag alone. The request shows as a one-cycle `dbg_irq` pulse in the cycle after the next `sample_pt`.
- R8: A falling edge that arrives while a request is pending or in service is dropped. After issue, the request stays in service until `dbg_irq_done`.
- R9: While control bit 0 is 1, `clk_out_en` is 0. Writes store `req_wdata[1:0]`, and reads return the control bits at [1:0].
- R10: Read bits [23:20] give the revision level parameter, which is 0 by default. All other read bits not named above are 0.
- R11: After reset, the code is 000, all flags and control bits are 0, no request is pending, `dbg_irq` and `rsp_valid` are 0, and `clk_out_en` and `req_ready` are 1.
- R12: `req_ready` is 0 while `rsp_valid` is 1 and `rsp_ready` is 0. A stalled response keeps stable data until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Debugger request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data (bits [1:0] used) |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | DATA_W | Read response word |
| tdr_wr | input | 1 | Trigger-definition write strobe |
| tdr_levels | input | 2 | Breakpoint levels given with the strobe |
| lvl1_hit | input | 1 | Level-1 comparator match |
| lvl2_hit | input | 1 | Level-2 comparator match |
| ent_fault2 | input | 1 | Fault-on-fault debug entry |
| ent_hwtrig | input | 1 | Hardware-trigger debug entry |
| ent_halt | input | 1 | Halt-instruction debug entry |
| brk_pin_n | input | 1 | Active-low break pin, already synchronized |
| sample_pt | input | 1 | Per-instruction interrupt sample point |
| dbg_irq_done | input | 1 | Debug interrupt service finished |
| trace_busy | input | 1 | Trace port shows other data |
| trc_valid | output | 1 | Status nibble on trace port |
| trc_status | output | 4 | Breakpoint status nibble |
| cause_flags | output | 4 | Sticky debug-entry causes |
| dbg_irq | output | 1 | Debug interrupt pulse |
| clk_out_en | output | 1 | Processor status clock enable |

## Verification
The hardest situations to reach are timing collisions. One is a cause event in the exact cycle a read is accepted. Another is a second pin edge that lands while a request is still pending, or while one is already in service. The bench drives the cause pulse together with the read request at the same clock edge. It then toggles the pin twice between sample points, and once more during service. It confirms that exactly one pulse comes out, by watching `dbg_irq` across the later sample points.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;
  localparam int NIB_W     = 4;
  localparam int CAUSE_N   = 4;
  localparam int CTRL_W    = 2;
  localparam int REV_W     = 4;
  localparam int STS_LSB   = 28;
  localparam int CAUSE_LSB = 24;
  localparam int REV_LSB   = 20;
  localparam int K_CLKOFF  = 0;
  localparam int K_PINIRQ  = 1;

  typedef enum logic [2:0] {
    BS_IDLE  = 3'b000,
    BS_WAIT1 = 3'b001,
    BS_HIT1  = 3'b010,
    BS_WAIT2 = 3'b101,
    BS_HIT2  = 3'b110
  } bkpt_code_e;

  typedef enum logic [1:0] {
    IRQ_IDLE = 2'd0,
    IRQ_PEND = 2'd1,
    IRQ_SERV = 2'd2
  } irq_st_e;
endpackage

// File: rtl/dbg_bkpt_seq.sv
module dbg_bkpt_seq
  import dbg_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tdr_wr,
  input  logic [1:0]       tdr_levels,
  input  logic             lvl1_hit,
  input  logic             lvl2_hit,
  output logic [NIB_W-1:0] nibble
);
  bkpt_code_e code_q, code_d;
  logic       two_lvl_q;

  always_comb begin
    code_d = code_q;
    if (tdr_wr) begin
      code_d = (tdr_levels == 2'b00) ? BS_IDLE : BS_WAIT1;
    end else begin
      case (code_q)
        BS_WAIT1: if (lvl1_hit) code_d = two_lvl_q ? BS_WAIT2 : BS_HIT1;
        BS_WAIT2: if (lvl2_hit) code_d = BS_HIT2;
        default:  code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q    <= BS_IDLE;
      two_lvl_q <= 1'b0;
    end else begin
      code_q <= code_d;
      if (tdr_wr) two_lvl_q <= tdr_levels[1];
    end
  end

  assign nibble = {code_q, 1'b0};

  AST_L1_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tdr_wr && code_q == BS_WAIT1 && lvl1_hit) |=> (code_q inside {BS_HIT1, BS_WAIT2})); // R1
  AST_HIT2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tdr_wr && code_q == BS_HIT2) |=> (code_q == BS_HIT2)); // R2
  AST_TDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tdr_wr |=> (code_q inside {BS_IDLE, BS_WAIT1})); // R3
endmodule

// File: rtl/dbg_cause_flags.sv
module dbg_cause_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= set_vec[i] | (f_q & ~rd_clr);
    end
    assign flags[i] = f_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !set_vec[i]) |=> !flags[i]); // R4
  end
endmodule

// File: rtl/dbg_irq_gen.sv
module dbg_irq_gen
  import dbg_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_irq,
  input  logic pin_n,
  input  logic sample_pt,
  input  logic done,
  output logic irq,
  output logic pin_evt
);
  irq_st_e st_q;
  logic    pin_q;
  logic    irq_q;
  logic    fall;

  assign fall    = pin_q & ~pin_n;
  assign pin_evt = ~mode_irq & ~pin_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= IRQ_IDLE;
      pin_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      pin_q <= pin_n;
      irq_q <= 1'b0;
      case (st_q)
        IRQ_IDLE: if (mode_irq && fall) st_q <= IRQ_PEND;
        IRQ_PEND: if (sample_pt) begin
          st_q  <= IRQ_SERV;
          irq_q <= 1'b1;
        end
        IRQ_SERV: if (done) st_q <= IRQ_IDLE;
        default:  st_q <= IRQ_IDLE;
      endcase
    end
  end

  assign irq = irq_q;

  AST_IRQ_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sample_pt)); // R7
  AST_IRQ_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_NORMAL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == IRQ_IDLE) |=> !irq); // R7
endmodule

// File: rtl/dbg_csr.sv
module dbg_csr
  import dbg_csr_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [REV_W-1:0]  REV_LEVEL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              tdr_wr,
  input  logic [1:0]        tdr_levels,
  input  logic              lvl1_hit,
  input  logic              lvl2_hit,
  input  logic              ent_fault2,
  input  logic              ent_hwtrig,
  input  logic              ent_halt,
  input  logic              brk_pin_n,
  input  logic              sample_pt,
  input  logic              dbg_irq_done,
  input  logic              trace_busy,
  output logic              trc_valid,
  output logic [NIB_W-1:0]  trc_status,
  output logic [CAUSE_N-1:0] cause_flags,
  output logic              dbg_irq,
  output logic              clk_out_en
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NIB_W-1:0]   nibble;
  logic [CAUSE_N-1:0] set_vec;
  logic               pin_evt;
  logic               rd_acc, wr_acc;
  logic [DATA_W-1:0]  rd_word;
  logic               unused_wbits;

  assign unused_wbits = ^req_wdata[DATA_W-1:CTRL_W];

  assign req_ready = ~rsp_valid | rsp_ready;
  assign rd_acc    = req_valid & req_ready & ~req_write;
  assign wr_acc    = req_valid & req_ready &  req_write;

  dbg_bkpt_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tdr_wr     (tdr_wr),
    .tdr_levels (tdr_levels),
    .lvl1_hit   (lvl1_hit),
    .lvl2_hit   (lvl2_hit),
    .nibble     (nibble)
  );

  dbg_irq_gen u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_irq  (ctrl_q[K_PINIRQ]),
    .pin_n     (brk_pin_n),
    .sample_pt (sample_pt),
    .done      (dbg_irq_done),
    .irq       (dbg_irq),
    .pin_evt   (pin_evt)
  );

  assign set_vec = {ent_fault2, ent_hwtrig, ent_halt, pin_evt};

  dbg_cause_flags #(.N(CAUSE_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .rd_clr  (rd_acc),
    .flags   (cause_flags)
  );

  always_comb begin
    rd_word = '0;
    rd_word[STS_LSB +: NIB_W]     = nibble;
    rd_word[CAUSE_LSB +: CAUSE_N] = cause_flags;
    rd_word[REV_LSB +: REV_W]     = REV_LEVEL;
    rd_word[CTRL_W-1:0]           = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (wr_acc) ctrl_q <= req_wdata[CTRL_W-1:0];
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign trc_valid  = ~trace_busy;
  assign trc_status = nibble;
  assign clk_out_en = ~ctrl_q[K_CLKOFF];

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R12
  AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_wdata[K_CLKOFF]) |=> !clk_out_en); // R9
endmodule

// File: tb/sim_dbg_csr.sv
`timescale 1ns/1ps
module sim_dbg_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, rsp_ready;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        tdr_wr, lvl1_hit, lvl2_hit;
  logic [1:0]  tdr_levels;
  logic        ent_fault2, ent_hwtrig, ent_halt, brk_pin_n, sample_pt, dbg_irq_done, trace_busy;
  logic        trc_valid, dbg_irq, clk_out_en;
  logic [3:0]  trc_status, cause_flags;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dbg_csr u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .tdr_wr(tdr_wr),
    .tdr_levels(tdr_levels), .lvl1_hit(lvl1_hit), .lvl2_hit(lvl2_hit),
    .ent_fault2(ent_fault2), .ent_hwtrig(ent_hwtrig), .ent_halt(ent_halt),
    .brk_pin_n(brk_pin_n), .sample_pt(sample_pt), .dbg_irq_done(dbg_irq_done),
    .trace_busy(trace_busy), .trc_valid(trc_valid), .trc_status(trc_status),
    .cause_flags(cause_flags), .dbg_irq(dbg_irq), .clk_out_en(clk_out_en)
  );

  function automatic logic [31:0] w(input logic [2:0] c, input logic [3:0] f, input logic [1:0] k);
    return {c, 1'b0, f, 4'h0, 18'b0, k};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] exp, input string tag);
    req_valid = 1'b1;
    req_write = 1'b0;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] k);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_wdata = {30'h2aaaaaa8 >> 0, k} | 32'hfffffffc;
    req_wdata[1:0] = k;
    while (!req_ready) @(negedge clk);
    tick();
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic tdr(input logic [1:0] lv);
    tdr_wr = 1'b1;
    tdr_levels = lv;
    tick();
    tdr_wr = 1'b0;
  endtask

  // monitor: scoreboard pop on response transfer
  always begin
    @(negedge clk);
    #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk("R12 unexpected response", rsp_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rsp_data, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog all-reqs act=%0d exp=done", total);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_wdata = '0; rsp_ready = 1'b1;
    tdr_wr = 0; tdr_levels = 0; lvl1_hit = 0; lvl2_hit = 0;
    ent_fault2 = 0; ent_hwtrig = 0; ent_halt = 0; brk_pin_n = 1'b1;
    sample_pt = 0; dbg_irq_done = 0; trace_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 trc_status", {28'b0, trc_status}, 32'h0);
    chk("R11 clk_out_en", {31'b0, clk_out_en}, 32'h1);
    chk("R11 req_ready", {31'b0, req_ready}, 32'h1);
    chk("R11 dbg_irq", {31'b0, dbg_irq}, 32'h0);
    chk("R11 cause_flags", {28'b0, cause_flags}, 32'h0);
    rd(w(3'b000, 4'h0, 2'b00), "R10 R11 reset read word");

    // R9 clock disable
    wr(2'b01);
    chk("R9 clk_out_en off", {31'b0, clk_out_en}, 32'h0);
    rd(w(3'b000, 4'h0, 2'b01), "R9 control readback");
    wr(2'b00);
    chk("R9 clk_out_en on", {31'b0, clk_out_en}, 32'h1);

    // R4 sticky flags, clear on read
    ent_fault2 = 1'b1; tick(); ent_fault2 = 1'b0;
    tick();
    chk("R4 fault flag sticky", {28'b0, cause_flags}, 32'h8);
    rd(w(3'b000, 4'h8, 2'b00), "R4 fault flag read");
    rd(w(3'b000, 4'h0, 2'b00), "R4 flag cleared by read");
    ent_hwtrig = 1'b1; ent_halt = 1'b1; tick(); ent_hwtrig = 1'b0; ent_halt = 1'b0;
    rd(w(3'b000, 4'h6, 2'b00), "R4 trigger and halt flags");
    tick();
    chk("R4 flags clear after read", {28'b0, cause_flags}, 32'h0);

    // R5 set beats clear
    req_valid = 1'b1; req_write = 1'b0; ent_halt = 1'b1;
    exp_q.push_back(w(3'b000, 4'h0, 2'b00)); tag_q.push_back("R5 read during set");
    tick();
    req_valid = 1'b0; ent_halt = 1'b0;
    chk("R5 flag survives read", {28'b0, cause_flags}, 32'h2);
    rd(w(3'b000, 4'h2, 2'b00), "R5 flag seen next read");
    rd(w(3'b000, 4'h0, 2'b00), "R5 flag then cleared");

    // R7 normal pin mode: flag, no irq
    brk_pin_n = 1'b0; tick(); brk_pin_n = 1'b1;
    sample_pt = 1'b1; tick(); sample_pt = 1'b0;
    chk("R7 normal mode no irq", {31'b0, dbg_irq}, 32'h0);
    rd(w(3'b000, 4'h1, 2'b00), "R7 pin flag normal mode");

    // R7 interrupt mode
    wr(2'b10);
    brk_pin_n = 1'b0; tick();
    chk("R7 pending waits for sample", {31'b0, dbg_irq}, 32'h0);
    tick();
    chk("R7 still waiting", {31'b0, dbg_irq}, 32'h0);
    sample_pt = 1'b1; tick(); sample_pt = 1'b0;
    chk("R7 irq at sample point", {31'b0, dbg_irq}, 32'h1);
    tick();
    chk("R7 irq single pulse", {31'b0, dbg_irq}, 32'h0);
    rd(w(3'b000, 4'h0, 2'b10), "R7 no pin flag in irq mode");

    // R8 no nesting during service
    brk_pin_n = 1'b1; tick(); brk_pin_n = 1'b0; tick();
    sample_pt = 1'b1; tick(); sample_pt = 1'b0;
    chk("R8 edge in service dropped", {31'b0, dbg_irq}, 32'h0);
    dbg_irq_done = 1'b1; tick(); dbg_irq_done = 1'b0;
    sample_pt = 1'b1; tick(); sample_pt = 1'b0;
    chk("R8 dropped edge not queued", {31'b0, dbg_irq}, 32'h0);
    // two edges while pending give one request
    brk_pin_n = 1'b1; tick(); brk_pin_n = 1'b0; tick();
    brk_pin_n = 1'b1; tick(); brk_pin_n = 1'b0; tick();
    sample_pt = 1'b1; tick();
    chk("R8 first sample issues", {31'b0, dbg_irq}, 32'h1);
    tick(); sample_pt = 1'b0;
    chk("R8 second edge not queued", {31'b0, dbg_irq}, 32'h0);
    dbg_irq_done = 1'b1; tick(); dbg_irq_done = 1'b0;
    brk_pin_n = 1'b1;
    wr(2'b00);

    // R1 single level
    tdr(2'b01);
    chk("R1 waiting level 1", {28'b0, trc_status}, 32'h2);
    lvl2_hit = 1'b1; tick(); lvl2_hit = 1'b0;
    chk("R1 level 2 hit ignored", {28'b0, trc_status}, 32'h2);
    lvl1_hit = 1'b1; tick(); lvl1_hit = 1'b0;
    chk("R1 level 1 triggered", {28'b0, trc_status}, 32'h4);
    lvl1_hit = 1'b1; tick(); lvl1_hit = 1'b0;
    chk("R1 triggered holds", {28'b0, trc_status}, 32'h4);

    // R2 two level
    tdr(2'b10);
    chk("R2 restart waits level 1", {28'b0, trc_status}, 32'h2);
    lvl1_hit = 1'b1; tick(); lvl1_hit = 1'b0;
    chk("R2 waiting level 2", {28'b0, trc_status}, 32'hA);
    lvl1_hit = 1'b1; tick(); lvl1_hit = 1'b0;
    chk("R2 level 1 hit at wait2 ignored", {28'b0, trc_status}, 32'hA);
    lvl2_hit = 1'b1; tick(); lvl2_hit = 1'b0;
    chk("R2 level 2 triggered", {28'b0, trc_status}, 32'hC);
    rd(w(3'b110, 4'h0, 2'b00), "R2 status in read word");

    // R3 trigger-definition write resets
    tdr(2'b00);
    chk("R3 disable to idle", {28'b0, trc_status}, 32'h0);
    lvl1_hit = 1'b1; tick(); lvl1_hit = 1'b0;
    chk("R3 hit ignored when idle", {28'b0, trc_status}, 32'h0);
    lvl1_hit = 1'b1; tdr(2'b11); lvl1_hit = 1'b0;
    chk("R3 write wins over hit", {28'b0, trc_status}, 32'h2);

    // R6 trace port
    chk("R6 trc_valid free", {31'b0, trc_valid}, 32'h1);
    trace_busy = 1'b1; #1;
    chk("R6 trc_valid busy", {31'b0, trc_valid}, 32'h0);
    trace_busy = 1'b0; #1;
    chk("R6 trc_valid free again", {31'b0, trc_valid}, 32'h1);
    @(negedge clk);

    // R12 back-pressure
    rsp_ready = 1'b0;
    rd(w(3'b001, 4'h0, 2'b00), "R12 stalled response data");
    chk("R12 valid held", {31'b0, rsp_valid}, 32'h1);
    chk("R12 ready low while stalled", {31'b0, req_ready}, 32'h0);
    ent_fault2 = 1'b1; tick(); ent_fault2 = 1'b0;
    tick();
    chk("R12 still stalled", {31'b0, req_ready}, 32'h0);
    rsp_ready = 1'b1;
    tick();
    chk("R12 slot free", {31'b0, rsp_valid}, 32'h0);
    rd(w(3'b001, 4'h8, 2'b00), "R12 next read after stall");
    tick(); tick();
    chk("R12 scoreboard drained", exp_q.size(), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule